// File: doc/BRIEF.md
# Prescaled Sleep Timer with Two Compare Channels

This block is a 16-bit free-running counter for a domain that stays powered while the rest of the chip sleeps. It advances on one-cycle tick pulses from one of two slow time bases, a 32.768 kHz tick or a calibrated 1 kHz tick. The selected tick stream passes through a power-of-two prescaler before it reaches the counter. The prescaler exponent is limited to 0 through 10, so at the slowest setting (1 kHz base, exponent 10) one full wrap of the counter takes 2^26 ms, roughly 67109 s.

Two compare channels watch the counter. When the counter steps onto a channel's compare value and that channel is enabled, the channel sets a sticky interrupt flag. The flag stays set until software pulses the channel's clear input. Only channel A can wake the system: the wake output follows flag A for as long as channel A is enabled. Channel B raises its own flag and never affects wake.

Top module: `sleep_timer`

## Requirements
- R1: `count_o` holds its value except on a prescaled step, when it increases by one. 16'hFFFF steps to 16'h0000. A step shows on `count_o` one clock after the tick that causes it.
- R2: `src_sel_i` = 0 selects `tick_fast_i` and `src_sel_i` = 1 selects `tick_slow_i`. Pulses on the unselected tick input have no effect on the count.
- R3: With an effective exponent n, a step occurs on every 2^n-th selected tick. Counting of ticks starts fresh after reset or after a configuration change.
- R4: A value of `shift_i` above 10 behaves exactly like 10, so a step occurs every 1024 selected ticks.
- R5: If `src_sel_i` or the effective exponent differs from its value in the previous cycle, the prescaler phase restarts at zero and `count_o` keeps its value. A tick arriving in that same cycle is discarded.
- R6: When a step makes the new count equal to `cmp_a_i` (or `cmp_b_i`) and that channel's enable is high, the channel's flag is set in the same clock in which the new count appears. A counter that only sits at the compare value sets nothing.
- R7: A flag stays set until its clear input is high at a clock edge. If a match and a clear happen in the same cycle, the match wins and the flag stays set.
- R8: `wake_o` is high exactly when flag A is set and `cmp_a_en_i` is high. Flag B never drives `wake_o`.
- R9: A match on a channel whose enable is low leaves that channel's flag unchanged.
- R10: While `rst_n` is low the count, both flags and `wake_o` are zero, and the prescaler phase and the stored configuration are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the always-on domain |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_fast_i | input | 1 | One-cycle pulse per 32.768 kHz period |
| tick_slow_i | input | 1 | One-cycle pulse per calibrated 1 kHz period |
| src_sel_i | input | 1 | Time base select: 0 fast tick, 1 slow tick |
| shift_i | input | 4 | Prescaler exponent; values above 10 act as 10 |
| cmp_a_i | input | 16 | Compare value, channel A |
| cmp_b_i | input | 16 | Compare value, channel B |
| cmp_a_en_i | input | 1 | Enable for channel A match and wake |
| cmp_b_en_i | input | 1 | Enable for channel B match |
| clr_a_i | input | 1 | Clears flag A at the clock edge |
| clr_b_i | input | 1 | Clears flag B at the clock edge |
| count_o | output | 16 | Current counter value |
| flag_a_o | output | 1 | Sticky interrupt flag, channel A |
| flag_b_o | output | 1 | Sticky interrupt flag, channel B |
| wake_o | output | 1 | Wake request, driven by channel A only |

## Verification
The properties assume that tick inputs are single-cycle pulses and that all inputs change only between clock edges. They also assume that compare values may change at any time, because a match is judged only on the step cycle. The stimulus drives every input on the falling edge and generates ticks from fixed periods, sometimes one per cycle. It moves the compare values relative to the count predicted by the model, so that matches, clears, disabled channels and set/clear collisions all occur. Configuration changes are made both between ticks and on cycles that carry a tick, so the rule that the same-cycle tick is discarded is exercised as well.

// File: rtl/st_pkg.sv
package st_pkg;
  localparam int ST_CNT_W     = 16;
  localparam int ST_SHIFT_W   = 4;
  localparam int ST_MAX_SHIFT = 10;
  localparam int ST_DIV_W     = ST_MAX_SHIFT;
  localparam int ST_NUM_CMP   = 2;

  typedef struct packed {
    logic                  src;
    logic [ST_SHIFT_W-1:0] shift;
  } st_cfg_t;

  // Clamp a requested exponent to the supported range.
  function automatic logic [ST_SHIFT_W-1:0] clamp_shift(input logic [ST_SHIFT_W-1:0] raw);
    if (int'(raw) > ST_MAX_SHIFT) return ST_SHIFT_W'(ST_MAX_SHIFT);
    return raw;
  endfunction

  // Last phase value before a step: 2^n - 1 as a mask of n ones.
  function automatic logic [ST_DIV_W-1:0] phase_limit(input logic [ST_SHIFT_W-1:0] n);
    logic [ST_DIV_W-1:0] v;
    for (int i = 0; i < ST_DIV_W; i++) v[i] = (i < int'(n));
    return v;
  endfunction
endpackage

// File: rtl/st_prescaler.sv
module st_prescaler
  import st_pkg::*;
#(
  parameter int DIV_W   = ST_DIV_W,
  parameter int SHIFT_W = ST_SHIFT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_fast,
  input  logic               tick_slow,
  input  logic               sel,
  input  logic [SHIFT_W-1:0] shift_raw,
  output logic               step_o,
  output logic               chg_o,
  output logic [DIV_W-1:0]   div_o
);
  st_cfg_t          cur_cfg, cfg_q;
  logic [DIV_W-1:0] div_q, limit;
  logic             tick_sel, at_limit;

  assign cur_cfg.src   = sel;
  assign cur_cfg.shift = clamp_shift(shift_raw);
  assign limit         = phase_limit(cur_cfg.shift);
  assign tick_sel      = sel ? tick_slow : tick_fast;
  assign chg_o         = (cur_cfg != cfg_q);
  assign at_limit      = (div_q == limit);
  assign step_o        = tick_sel & ~chg_o & at_limit;
  assign div_o         = div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      div_q <= '0;
    end else begin
      cfg_q <= cur_cfg;
      if (chg_o)         div_q <= '0;
      else if (tick_sel) div_q <= at_limit ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/st_counter.sv
module st_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] next_o
);
  logic [CNT_W-1:0] cnt_q;

  assign next_o  = cnt_q + 1'b1;
  assign count_o = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= next_o;
  end
endmodule

// File: rtl/st_compare.sv
module st_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] next_count,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             en,
  input  logic             clr,
  output logic             hit_o,
  output logic             flag_o
);
  logic flag_q;

  assign hit_o  = step & en & (next_count == cmp_val);
  assign flag_o = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= hit_o | (flag_q & ~clr);
  end
endmodule

// File: rtl/sleep_timer.sv
module sleep_timer
  import st_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_fast_i,
  input  logic                  tick_slow_i,
  input  logic                  src_sel_i,
  input  logic [ST_SHIFT_W-1:0] shift_i,
  input  logic [ST_CNT_W-1:0]   cmp_a_i,
  input  logic [ST_CNT_W-1:0]   cmp_b_i,
  input  logic                  cmp_a_en_i,
  input  logic                  cmp_b_en_i,
  input  logic                  clr_a_i,
  input  logic                  clr_b_i,
  output logic [ST_CNT_W-1:0]   count_o,
  output logic                  flag_a_o,
  output logic                  flag_b_o,
  output logic                  wake_o
);
  logic                step_w, chg_w;
  logic [ST_DIV_W-1:0] div_w;
  logic [ST_CNT_W-1:0] next_w;

  logic [ST_CNT_W-1:0] cmp_val [ST_NUM_CMP];
  logic                cmp_en  [ST_NUM_CMP];
  logic                cmp_clr [ST_NUM_CMP];
  logic                hit_w   [ST_NUM_CMP];
  logic                flag_w  [ST_NUM_CMP];
  logic                hit_a_w, hit_b_w;

  assign cmp_val[0] = cmp_a_i;
  assign cmp_val[1] = cmp_b_i;
  assign cmp_en[0]  = cmp_a_en_i;
  assign cmp_en[1]  = cmp_b_en_i;
  assign cmp_clr[0] = clr_a_i;
  assign cmp_clr[1] = clr_b_i;

  st_prescaler #(.DIV_W(ST_DIV_W), .SHIFT_W(ST_SHIFT_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_fast (tick_fast_i),
    .tick_slow (tick_slow_i),
    .sel       (src_sel_i),
    .shift_raw (shift_i),
    .step_o    (step_w),
    .chg_o     (chg_w),
    .div_o     (div_w)
  );

  st_counter #(.CNT_W(ST_CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step_w),
    .count_o (count_o),
    .next_o  (next_w)
  );

  for (genvar g = 0; g < ST_NUM_CMP; g++) begin : g_cmp
    st_compare #(.CNT_W(ST_CNT_W)) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (step_w),
      .next_count (next_w),
      .cmp_val    (cmp_val[g]),
      .en         (cmp_en[g]),
      .clr        (cmp_clr[g]),
      .hit_o      (hit_w[g]),
      .flag_o     (flag_w[g])
    );
  end

  assign hit_a_w  = hit_w[0];
  assign hit_b_w  = hit_w[1];
  assign flag_a_o = flag_w[0];
  assign flag_b_o = flag_w[1];
  // Only channel A may request a wake.
  assign wake_o   = flag_w[0] & cmp_a_en_i;
endmodule

// File: rtl/st_checker.sv
module st_checker
  import st_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                step,
  input logic                chg,
  input logic [ST_DIV_W-1:0] div,
  input logic [ST_CNT_W-1:0] count,
  input logic                hit_a,
  input logic                hit_b,
  input logic                flag_a,
  input logic                flag_b,
  input logic                wake,
  input logic                en_a,
  input logic                clr_a,
  input logic                clr_b
);
  a_r1_increment: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> count == ST_CNT_W'($past(count) + 1'b1));
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(count));
  a_r5_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> div == '0);
  a_r5_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> !step);
  a_r6_flag_a_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a |=> flag_a);
  a_r6_flag_b_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b |=> flag_b);
  a_r7_sticky_a: assert property (@(posedge clk) disable iff (!rst_n)
    flag_a && !clr_a |=> flag_a);
  a_r7_sticky_b: assert property (@(posedge clk) disable iff (!rst_n)
    flag_b && !clr_b |=> flag_b);
  a_r8_b_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b && !hit_a && !flag_a |=> !wake);
  a_r9_disabled_a: assert property (@(posedge clk) disable iff (!rst_n)
    !en_a && !flag_a |=> !flag_a);
endmodule

bind sleep_timer st_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .step   (step_w),
  .chg    (chg_w),
  .div    (div_w),
  .count  (count_o),
  .hit_a  (hit_a_w),
  .hit_b  (hit_b_w),
  .flag_a (flag_a_o),
  .flag_b (flag_b_o),
  .wake   (wake_o),
  .en_a   (cmp_a_en_i),
  .clr_a  (clr_a_i),
  .clr_b  (clr_b_i)
);

// File: tb/sleep_timer_bench.sv
module sleep_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_fast_i = 1'b0, tick_slow_i = 1'b0, src_sel_i = 1'b0;
  logic [3:0]  shift_i = 4'd0;
  logic [15:0] cmp_a_i = 16'd0, cmp_b_i = 16'd0;
  logic        cmp_a_en_i = 1'b0, cmp_b_en_i = 1'b0, clr_a_i = 1'b0, clr_b_i = 1'b0;
  logic [15:0] count_o;
  logic        flag_a_o, flag_b_o, wake_o;

  always #4 clk = ~clk;

  sleep_timer u_sleep_timer (.*);

  int    vectors = 0, miscompares = 0;
  string req_tag = "R10";
  bit    done = 0;

  // Behavioural reference model
  int m_cnt = 0, m_pre = 0, m_pn = 0;
  bit m_psel = 0, m_fa = 0, m_fb = 0;

  always @(posedge clk) begin
    int n; bit t, chg, stp;
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_pn = 0; m_psel = 0; m_fa = 0; m_fb = 0;
    end else begin
      n   = (shift_i > 10) ? 10 : int'(shift_i);
      t   = src_sel_i ? tick_slow_i : tick_fast_i;
      chg = (src_sel_i != m_psel) || (n != m_pn);
      m_psel = src_sel_i; m_pn = n;
      stp = 0;
      if (chg) m_pre = 0;
      else if (t) begin
        if (m_pre == (1 << n) - 1) begin m_pre = 0; stp = 1; end
        else m_pre++;
      end
      if (stp) m_cnt = (m_cnt + 1) % 65536;
      m_fa = (stp && cmp_a_en_i && m_cnt == int'(cmp_a_i)) || (m_fa && !clr_a_i);
      m_fb = (stp && cmp_b_en_i && m_cnt == int'(cmp_b_i)) || (m_fb && !clr_b_i);
    end
  end

  task automatic chk(string what, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req_tag, what, act, exp, $time);
    end
  endtask

  // Compare at the falling edge, before new inputs are driven.
  task automatic compare();
    vectors++;
    chk("count (R1)", int'(count_o), m_cnt);
    chk("flag_a (R6/R7)", int'(flag_a_o), int'(m_fa));
    chk("flag_b (R6/R7)", int'(flag_b_o), int'(m_fb));
    chk("wake (R8)", int'(wake_o), int'(m_fa && cmp_a_en_i));
  endtask

  // Run cycles with periodic ticks; period 0 means none.
  task automatic run(int cycles, int fp, int sp);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare();
      tick_fast_i = (fp != 0) && (c % fp == 0);
      tick_slow_i = (sp != 0) && (c % sp == 0);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired in phase %s", req_tag);
    finish_up();
  end

  initial begin
    // R10: outputs are zero while reset is held, even with ticks present
    req_tag = "R10";
    shift_i = 4'd0; src_sel_i = 1'b0;
    repeat (3) begin
      @(negedge clk); compare(); tick_fast_i = 1'b1;
    end
    @(negedge clk); rst_n = 1'b1; tick_fast_i = 1'b0;

    // R1: one step per cycle, full wrap, A matches at 0 and B at 0x1234
    req_tag = "R1";
    cmp_a_i = 16'h0000; cmp_b_i = 16'h1234; cmp_a_en_i = 1; cmp_b_en_i = 1;
    run(66000, 1, 0);
    @(negedge clk); compare(); clr_a_i = 1; clr_b_i = 1;
    @(negedge clk); compare(); clr_a_i = 0; clr_b_i = 0;

    // R3: exponent 3, fast tick every 2 cycles, slow tick also present
    req_tag = "R3";
    shift_i = 4'd3;
    run(3000, 2, 7);

    // R2: slow source selected, fast pulses every cycle are ignored
    req_tag = "R2";
    src_sel_i = 1'b1; shift_i = 4'd2;
    run(3000, 1, 3);
    src_sel_i = 1'b0;
    run(500, 0, 1);

    // R4: exponents 15 and 12 must behave like 10
    req_tag = "R4";
    shift_i = 4'd15;
    run(6000, 1, 0);
    shift_i = 4'd12;
    run(6000, 1, 0);
    shift_i = 4'd10;
    run(2200, 1, 0);

    // R5: config changes mid-phase, some on tick cycles
    req_tag = "R5";
    for (int k = 0; k < 80; k++) begin
      shift_i = (k % 2) ? 4'd4 : 4'd5;
      if (k % 5 == 0) src_sel_i = ~src_sel_i;
      run(37, 1, 2);
    end
    src_sel_i = 1'b0;

    // R6, R7, R8, R9: compares placed ahead of the count
    shift_i = 4'd0;
    for (int it = 0; it < 60; it++) begin
      req_tag = (it % 4 == 0) ? "R7" : (it % 3 == 0) ? "R9" : (it % 2 == 0) ? "R8" : "R6";
      cmp_a_i = 16'((m_cnt + 2) % 65536);
      cmp_b_i = 16'((m_cnt + 3) % 65536);
      cmp_a_en_i = (it % 3 != 0);
      cmp_b_en_i = (it % 2 == 1);
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        compare();
        tick_fast_i = (c % 4 == 0);
        clr_a_i = (it % 4 == 0) && (c == 8 || c == 4);
        clr_b_i = (it % 4 == 0) && (c == 12);
      end
      // hold count, toggle enable A to watch wake gating
      tick_fast_i = 0; clr_a_i = 0; clr_b_i = 0;
      run(3, 0, 0);
      cmp_a_en_i = ~cmp_a_en_i;
      run(3, 0, 0);
      if (it % 5 == 0) begin
        clr_a_i = 1; clr_b_i = 1;
        run(1, 0, 0);
        clr_a_i = 0; clr_b_i = 0;
      end
    end
    run(4, 0, 0);
    finish_up();
  end
endmodule